// File: doc/BRIEF.md
# Straddled Packet Beat Splitter

This block sits on the receive side of a wide request stream in which each 16-dword beat can hold parts of two transaction-layer packets. The stream carries no usable end marker or dword keep mask. Each beat instead carries coded sideband fields: a start code and start positions for the packets that begin in it, an end code and last-dword offsets for the packets that finish in it, a drop request and poison flags. The block decodes these fields against a one-bit record of whether a packet is still open from an earlier beat. It then presents each beat as two ordered lane descriptors, so downstream logic can work on one packet segment at a time.

Lane 0 always describes the segment that occupies the lower part of the beat. That segment is either the continuation of an open packet or the first new packet. Lane 1 describes a second segment, which can only start at dword 8. Every lane gives a valid bit, start and end markers, a first and last dword offset, a drop flag and a poison flag. Any reserved code or framing inconsistency sets a sticky `protocol_error`, which stays high until reset. The beat that caused the error is forwarded with both lanes empty.

Both stream sides use valid/ready. A beat moves on a cycle in which valid and ready are both high. The input is ready whenever the single output register is empty or is being drained in that same cycle. While the output is stalled, the block holds every output field unchanged. Each accepted input beat yields exactly one output beat, one cycle later, in order.

Top module: `straddle_splitter`

## Requirements
- R1: An input beat is taken on a cycle with `s_valid` and `s_ready` both high. `s_ready` is high when `m_valid` is low or `m_ready` is high. Each taken beat appears on the outputs with `m_valid` high after the next clock edge, in order. All outputs hold steady while `m_valid` is high and `m_ready` is low.
- R2: Lane bit k of each per-lane vector, and bits [4k+3:4k] of the offset vectors, belong to lane k. `s_sop` 2'b00 starts no packet, 2'b01 starts one and 2'b11 starts two. A start position of 2'b00 means dword 0 and 2'b10 means dword 8. A new packet's lane sets its start flag and reports that first dword. When two packets start, the second is in lane 1 at dword 8.
- R3: `s_eop` 2'b00/2'b01/2'b11 ends zero, one or two segments. Ends are given to the segments in lane order: offset 0 to lane 0 and offset 1 to lane 1. A valid lane that does not end reports last dword 15. Unused lanes are all zero.
- R4: If a packet is open from an earlier beat, lane 0 carries its continuation with the start flag clear and first dword 0. A packet that starts in the same beat goes to lane 1 at dword 8. A beat with no codes while a packet is open yields a lane 0 spanning dwords 0 to 15.
- R5: Poison bit 0 marks the first packet starting in the beat and poison bit 1 marks the second. Each is shown on the lane that carries that packet.
- R6: The drop request goes to lane 0, the segment ending with end offset 0. Lane 1 never shows a drop.
- R7: Reserved codes raise `protocol_error`: start code 2'b10, end code 2'b10, a first start position of 2'b01 or 2'b11, and on a two-start beat a first position other than 2'b00 or a second position other than 2'b10.
- R8: Framing faults raise `protocol_error`: more ends than segments, a segment other than the last left unended, a new start at dword 0 while a packet is open, and three segments in one beat.
- R9: `protocol_error` is also raised by a drop request on a beat where no segment ends, or on a beat that also holds a second segment. It is also raised by an end offset that falls outside its segment: lane 0 ending at or after dword 8 when lane 1 exists, or a packet that starts at dword 8 ending before it.
- R10: A faulty beat is forwarded with both lanes all zero and closes any open packet. `protocol_error` rises together with that beat's `m_valid` and stays high until reset, while later beats decode normally.
- R11: Synchronous reset clears `m_valid`, `protocol_error` and the open-packet state, so an end-only beat after reset is an orphan end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high with `s_valid` |
| s_sop | input | 2 | Start code for packets beginning in the beat |
| s_sop0_pos | input | 2 | Position of the first starting packet |
| s_sop1_pos | input | 2 | Position of the second starting packet |
| s_eop | input | 2 | End code for segments finishing in the beat |
| s_eop0_off | input | 4 | Last dword of the first ending segment |
| s_eop1_off | input | 4 | Last dword of the second ending segment |
| s_discard | input | 1 | Drop request for the segment ending first |
| s_poison | input | 2 | Poison flags of the starting packets |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream ready |
| m_lane_vld | output | 2 | Lane holds a segment |
| m_lane_sop | output | 2 | Lane segment starts a packet |
| m_lane_eop | output | 2 | Lane segment ends a packet |
| m_lane_first_dw | output | 8 | First dword of each lane segment |
| m_lane_last_dw | output | 8 | Last dword of each lane segment |
| m_lane_drop | output | 2 | Lane packet must be dropped |
| m_lane_poison | output | 2 | Lane packet is poisoned |
| protocol_error | output | 1 | Sticky protocol violation flag |

## Verification
The only hidden state is the open-packet bit. If it is wrong, the next beat shows it: a continuation appears in lane 0 with a start flag or a dword-8 start, or a clean end is flagged as an orphan, or a start is refused. Each of these is visible on the output beat one cycle after acceptance. A sticky error that clears, or fails to rise, is visible on `protocol_error` in the same output cycle. A bad lane mapping shows directly as swapped offsets, misplaced poison or drop bits, or a non-15 last dword on an unended lane. Stall cycles on `m_ready` expose any output that moves while held.

// File: rtl/splitter_pkg.sv
package splitter_pkg;
  localparam int NLANE    = 2;
  localparam int DW_OFF_W = 4;

  typedef struct packed {
    logic                vld;
    logic                sop;
    logic                eop;
    logic [DW_OFF_W-1:0] first_dw;
    logic [DW_OFF_W-1:0] last_dw;
    logic                drop;
    logic                poison;
  } lane_t;

  localparam int LANE_W = $bits(lane_t);
endpackage

// File: rtl/splitter_decode.sv
module splitter_decode
  import splitter_pkg::*;
(
  input  logic                      in_pkt,
  input  logic [1:0]                sop,
  input  logic [1:0]                sop0_pos,
  input  logic [1:0]                sop1_pos,
  input  logic [1:0]                eop,
  input  logic [DW_OFF_W-1:0]       eop0_off,
  input  logic [DW_OFF_W-1:0]       eop1_off,
  input  logic                      discard,
  input  logic [1:0]                poison,
  output lane_t [NLANE-1:0]         lanes,
  output logic                      err,
  output logic                      nxt_open
);
  localparam logic [DW_OFF_W-1:0] HALF_DW = {1'b1, {(DW_OFF_W-1){1'b0}}};
  localparam logic [DW_OFF_W-1:0] LAST_DW = '1;

  logic [1:0]          n_sop, n_eop, n_seg;
  logic                bad_code, bad_frame, bad_drop, bad_pos;
  logic [DW_OFF_W-1:0] new_first;
  lane_t [NLANE-1:0]   raw;

  // Count codes and flag reserved encodings
  always_comb begin
    bad_code = 1'b0;
    unique case (sop)
      2'b00:   n_sop = 2'd0;
      2'b01:   n_sop = 2'd1;
      2'b11:   n_sop = 2'd2;
      default: begin n_sop = 2'd0; bad_code = 1'b1; end
    endcase
    unique case (eop)
      2'b00:   n_eop = 2'd0;
      2'b01:   n_eop = 2'd1;
      2'b11:   n_eop = 2'd2;
      default: begin n_eop = 2'd0; bad_code = 1'b1; end
    endcase
    if (sop[0] && sop0_pos[0]) bad_code = 1'b1;
    if (sop == 2'b11 && (sop1_pos != 2'b10 || sop0_pos != 2'b00)) bad_code = 1'b1;
  end

  assign n_seg     = {1'b0, in_pkt} + n_sop;
  assign new_first = (sop0_pos == 2'b10) ? HALF_DW : '0;

  assign bad_frame = (n_seg == 2'd3)
                   || (in_pkt && sop[0] && sop0_pos != 2'b10)
                   || (n_eop > n_seg)
                   || (n_seg == 2'd2 && n_eop == 2'd0);
  assign bad_drop  = discard && (n_eop == 2'd0 || n_seg == 2'd2);

  // Lane mapping: segments in position order, ends given in lane order
  always_comb begin
    raw = '0;
    if (n_seg != 2'd0) begin
      raw[0].vld      = 1'b1;
      raw[0].sop      = !in_pkt;
      raw[0].first_dw = in_pkt ? '0 : new_first;
      raw[0].eop      = (n_eop != 2'd0);
      raw[0].last_dw  = (n_eop != 2'd0) ? eop0_off : LAST_DW;
      raw[0].drop     = discard;
      raw[0].poison   = !in_pkt && poison[0];
    end
    if (n_seg == 2'd2) begin
      raw[1].vld      = 1'b1;
      raw[1].sop      = 1'b1;
      raw[1].first_dw = HALF_DW;
      raw[1].eop      = (n_eop == 2'd2);
      raw[1].last_dw  = (n_eop == 2'd2) ? eop1_off : LAST_DW;
      raw[1].drop     = 1'b0;
      raw[1].poison   = in_pkt ? poison[0] : poison[1];
    end
  end

  assign bad_pos = (raw[0].vld && raw[0].eop && raw[0].last_dw < raw[0].first_dw)
                || (raw[1].vld && raw[0].eop && eop0_off >= HALF_DW)
                || (raw[1].vld && raw[1].eop && eop1_off < HALF_DW);

  assign err      = bad_code || bad_frame || bad_drop || bad_pos;
  assign nxt_open = !err && (n_seg > n_eop);

  generate
    for (genvar k = 0; k < NLANE; k++) begin : g_mask
      assign lanes[k] = err ? '0 : raw[k];
    end
  endgenerate
endmodule

// File: rtl/splitter_stage.sv
module splitter_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_take_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);
endmodule

// File: rtl/straddle_splitter.sv
module straddle_splitter
  import splitter_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic [1:0]                s_sop,
  input  logic [1:0]                s_sop0_pos,
  input  logic [1:0]                s_sop1_pos,
  input  logic [1:0]                s_eop,
  input  logic [DW_OFF_W-1:0]       s_eop0_off,
  input  logic [DW_OFF_W-1:0]       s_eop1_off,
  input  logic                      s_discard,
  input  logic [1:0]                s_poison,
  output logic                      m_valid,
  input  logic                      m_ready,
  output logic [NLANE-1:0]          m_lane_vld,
  output logic [NLANE-1:0]          m_lane_sop,
  output logic [NLANE-1:0]          m_lane_eop,
  output logic [NLANE*DW_OFF_W-1:0] m_lane_first_dw,
  output logic [NLANE*DW_OFF_W-1:0] m_lane_last_dw,
  output logic [NLANE-1:0]          m_lane_drop,
  output logic [NLANE-1:0]          m_lane_poison,
  output logic                      protocol_error
);
  localparam logic [DW_OFF_W-1:0] HALF_DW = {1'b1, {(DW_OFF_W-1){1'b0}}};

  logic              open_q, err_q;
  logic              dec_err, dec_open, accept;
  lane_t [NLANE-1:0] dec_lanes;
  lane_t [NLANE-1:0] out_lanes;

  splitter_decode u_decode (
    .in_pkt   (open_q),
    .sop      (s_sop),
    .sop0_pos (s_sop0_pos),
    .sop1_pos (s_sop1_pos),
    .eop      (s_eop),
    .eop0_off (s_eop0_off),
    .eop1_off (s_eop1_off),
    .discard  (s_discard),
    .poison   (s_poison),
    .lanes    (dec_lanes),
    .err      (dec_err),
    .nxt_open (dec_open)
  );

  splitter_stage #(.W(NLANE*LANE_W)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .in_data   (dec_lanes),
    .out_valid (m_valid),
    .out_ready (m_ready),
    .out_data  (out_lanes)
  );

  assign accept = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (accept) begin
      open_q <= dec_open;
      err_q  <= err_q | dec_err;
    end
  end

  assign protocol_error = err_q;

  generate
    for (genvar k = 0; k < NLANE; k++) begin : g_lane
      assign m_lane_vld[k]    = out_lanes[k].vld;
      assign m_lane_sop[k]    = out_lanes[k].sop;
      assign m_lane_eop[k]    = out_lanes[k].eop;
      assign m_lane_drop[k]   = out_lanes[k].drop;
      assign m_lane_poison[k] = out_lanes[k].poison;
      assign m_lane_first_dw[k*DW_OFF_W +: DW_OFF_W] = out_lanes[k].first_dw;
      assign m_lane_last_dw[k*DW_OFF_W +: DW_OFF_W]  = out_lanes[k].last_dw;

      assert_span_order_R3: assert property (@(posedge clk) disable iff (rst)
        m_valid && out_lanes[k].vld |-> out_lanes[k].last_dw >= out_lanes[k].first_dw);
    end
  endgenerate

  assert_second_lane_R4: assert property (@(posedge clk) disable iff (rst)
    m_valid && m_lane_vld[1] |->
      m_lane_vld[0] && m_lane_sop[1] && m_lane_eop[0]
      && m_lane_first_dw[2*DW_OFF_W-1:DW_OFF_W] == HALF_DW);

  assert_drop_on_end_R6: assert property (@(posedge clk) disable iff (rst)
    m_valid && m_lane_drop[0] |-> m_lane_eop[0] && !m_lane_drop[1]);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    protocol_error |=> protocol_error);

  assert_err_empty_R10: assert property (@(posedge clk) disable iff (rst)
    accept && !err_q && !dec_err |=> !protocol_error);
endmodule

// File: tb/straddle_splitter_bench.sv
module straddle_splitter_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [1:0] vld, sop, eop;
    logic [7:0] fst, lst;
    logic [1:0] drp, poi;
    logic       err;
  } exp_t;

  logic       clk = 0, rst = 1;
  logic       s_valid = 0, s_ready;
  logic [1:0] s_sop = 0, s_sop0_pos = 0, s_sop1_pos = 0, s_eop = 0, s_poison = 0;
  logic [3:0] s_eop0_off = 0, s_eop1_off = 0;
  logic       s_discard = 0;
  logic       m_valid, m_ready = 1;
  logic [1:0] m_lane_vld, m_lane_sop, m_lane_eop, m_lane_drop, m_lane_poison;
  logic [7:0] m_lane_first_dw, m_lane_last_dw;
  logic       protocol_error;

  int checks = 0, errors = 0, cyc = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  straddle_splitter u_straddle_splitter (
    .clk(clk), .rst(rst), .s_valid(s_valid), .s_ready(s_ready),
    .s_sop(s_sop), .s_sop0_pos(s_sop0_pos), .s_sop1_pos(s_sop1_pos),
    .s_eop(s_eop), .s_eop0_off(s_eop0_off), .s_eop1_off(s_eop1_off),
    .s_discard(s_discard), .s_poison(s_poison),
    .m_valid(m_valid), .m_ready(m_ready),
    .m_lane_vld(m_lane_vld), .m_lane_sop(m_lane_sop), .m_lane_eop(m_lane_eop),
    .m_lane_first_dw(m_lane_first_dw), .m_lane_last_dw(m_lane_last_dw),
    .m_lane_drop(m_lane_drop), .m_lane_poison(m_lane_poison),
    .protocol_error(protocol_error)
  );

  function automatic exp_t ex(logic [1:0] vld, sop, eop, logic [7:0] fst, lst,
                              logic [1:0] drp, poi, logic err);
    exp_t e;
    e = '{vld: vld, sop: sop, eop: eop, fst: fst, lst: lst, drp: drp, poi: poi, err: err};
    return e;
  endfunction

  // Downstream back-pressure pattern, changed just after the clock edge (R1)
  initial forever begin
    @(posedge clk);
    #1;
    cyc++;
    m_ready = (cyc % 3) != 0;
  end

  // Driver: present a beat, wait for acceptance, push the expected result
  task automatic send(input logic [1:0] sop, p0, p1, eop, input logic [3:0] o0, o1,
                      input logic disc, input logic [1:0] poi, input exp_t e, input string tag);
    @(negedge clk);
    s_valid = 1; s_sop = sop; s_sop0_pos = p0; s_sop1_pos = p1;
    s_eop = eop; s_eop0_off = o0; s_eop1_off = o1; s_discard = disc; s_poison = poi;
    while (!s_ready) @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    s_valid = 0;
  endtask

  // Monitor: compare every output beat with the scoreboard head
  always @(negedge clk) begin
    if (!rst && m_valid && m_ready) begin
      exp_t a;
      a = '{vld: m_lane_vld, sop: m_lane_sop, eop: m_lane_eop, fst: m_lane_first_dw,
            lst: m_lane_last_dw, drp: m_lane_drop, poi: m_lane_poison, err: protocol_error};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected output beat actual=%h expected=none", a);
      end else begin
        exp_t e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, a, e);
        end
      end
    end
  end

  task automatic check_reset(input string tag);
    checks++;
    if (m_valid !== 1'b0 || protocol_error !== 1'b0 || s_ready !== 1'b1) begin
      errors++;
      $display("FAIL %s reset state actual=%b%b%b expected=001", tag, m_valid, protocol_error, s_ready);
    end
  endtask

  task automatic do_reset();
    wait (exp_q.size() == 0);
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    check_reset("R11");
  endtask

  localparam exp_t ERR = '{vld: 2'b00, sop: 2'b00, eop: 2'b00, fst: 8'h00, lst: 8'h00,
                           drp: 2'b00, poi: 2'b00, err: 1'b1};

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check_reset("R11");

    // Clean traffic
    send(2'b01, 2'b00, 2'b00, 2'b01, 4'd3, 4'd0, 0, 2'b00,
         ex(2'b01, 2'b01, 2'b01, 8'h00, 8'h03, 2'b00, 2'b00, 0), "R2 one start one end");
    send(2'b11, 2'b00, 2'b10, 2'b11, 4'd5, 4'd12, 0, 2'b10,
         ex(2'b11, 2'b11, 2'b11, 8'h80, 8'hC5, 2'b00, 2'b10, 0), "R3 R5 two starts two ends");
    send(2'b01, 2'b10, 2'b00, 2'b00, 4'd0, 4'd0, 0, 2'b01,
         ex(2'b01, 2'b01, 2'b00, 8'h08, 8'h0F, 2'b00, 2'b01, 0), "R2 start at dword 8 open");
    send(2'b00, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 0, 2'b00,
         ex(2'b01, 2'b00, 2'b00, 8'h00, 8'h0F, 2'b00, 2'b00, 0), "R4 middle beat");
    send(2'b01, 2'b10, 2'b00, 2'b01, 4'd6, 4'd0, 0, 2'b01,
         ex(2'b11, 2'b10, 2'b01, 8'h80, 8'hF6, 2'b00, 2'b10, 0), "R4 R5 end then new open");
    send(2'b01, 2'b10, 2'b00, 2'b11, 4'd2, 4'd15, 0, 2'b00,
         ex(2'b11, 2'b10, 2'b11, 8'h80, 8'hF2, 2'b00, 2'b00, 0), "R3 R4 end then new ends");
    send(2'b01, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 0, 2'b00,
         ex(2'b01, 2'b01, 2'b00, 8'h00, 8'h0F, 2'b00, 2'b00, 0), "R2 open at dword 0");
    send(2'b00, 2'b00, 2'b00, 2'b01, 4'd9, 4'd0, 1, 2'b00,
         ex(2'b01, 2'b00, 2'b01, 8'h00, 8'h09, 2'b01, 2'b00, 0), "R6 drop on end");
    send(2'b01, 2'b10, 2'b00, 2'b01, 4'd11, 4'd0, 0, 2'b00,
         ex(2'b01, 2'b01, 2'b01, 8'h08, 8'h0B, 2'b00, 2'b00, 0), "R2 single at dword 8");
    send(2'b00, 2'b00, 2'b00, 2'b00, 4'd0, 4'd0, 0, 2'b11,
         ex(2'b00, 2'b00, 2'b00, 8'h00, 8'h00, 2'b00, 2'b00, 0), "R3 idle beat empty lanes");

    // Reserved codes (R7)
    do_reset(); send(2'b10, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0, ERR, "R7 start code 10");
    do_reset(); send(2'b01, 2'b00, 2'b00, 2'b10, 3, 0, 0, 0, ERR, "R7 end code 10");
    do_reset(); send(2'b01, 2'b01, 2'b00, 2'b01, 3, 0, 0, 0, ERR, "R7 position 01");
    do_reset(); send(2'b01, 2'b11, 2'b00, 2'b01, 3, 0, 0, 0, ERR, "R7 position 11");
    do_reset(); send(2'b11, 2'b00, 2'b00, 2'b11, 3, 12, 0, 0, ERR, "R7 second position 00");
    do_reset(); send(2'b11, 2'b10, 2'b10, 2'b11, 3, 12, 0, 0, ERR, "R7 first position 10 on two starts");

    // Framing faults (R8)
    do_reset(); send(2'b00, 2'b00, 2'b00, 2'b01, 5, 0, 0, 0, ERR, "R8 orphan end");
    do_reset(); send(2'b11, 2'b00, 2'b10, 2'b00, 0, 0, 0, 0, ERR, "R8 unclosed first of two");
    do_reset();
    send(2'b01, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0,
         ex(2'b01, 2'b01, 2'b00, 8'h00, 8'h0F, 2'b00, 2'b00, 0), "R2 open");
    send(2'b01, 2'b10, 2'b00, 2'b00, 0, 0, 0, 0, ERR, "R8 start while open");
    send(2'b00, 2'b00, 2'b00, 2'b01, 5, 0, 0, 0, ERR, "R10 fault closed open packet");
    send(2'b01, 2'b00, 2'b00, 2'b01, 4, 0, 0, 2'b01,
         ex(2'b01, 2'b01, 2'b01, 8'h00, 8'h04, 2'b00, 2'b01, 1), "R10 sticky flag normal decode");
    do_reset();
    send(2'b01, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0,
         ex(2'b01, 2'b01, 2'b00, 8'h00, 8'h0F, 2'b00, 2'b00, 0), "R2 open");
    send(2'b01, 2'b00, 2'b00, 2'b01, 3, 0, 0, 0, ERR, "R8 start at dword 0 while open");
    do_reset();
    send(2'b01, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0,
         ex(2'b01, 2'b01, 2'b00, 8'h00, 8'h0F, 2'b00, 2'b00, 0), "R2 open");
    send(2'b11, 2'b00, 2'b10, 2'b11, 3, 12, 0, 0, ERR, "R8 three segments");

    // Drop misuse and offset order (R9)
    do_reset(); send(2'b01, 2'b00, 2'b00, 2'b00, 0, 0, 1, 0, ERR, "R9 drop without end");
    do_reset(); send(2'b11, 2'b00, 2'b10, 2'b11, 3, 12, 1, 0, ERR, "R9 drop with second start");
    do_reset(); send(2'b11, 2'b00, 2'b10, 2'b11, 9, 12, 0, 0, ERR, "R9 first end past half");
    do_reset(); send(2'b01, 2'b10, 2'b00, 2'b01, 4, 0, 0, 0, ERR, "R9 end before start");
    do_reset(); send(2'b11, 2'b00, 2'b10, 2'b11, 3, 5, 0, 0, ERR, "R9 second end before half");

    // Reset clears open state (R11)
    do_reset();
    send(2'b01, 2'b00, 2'b00, 2'b00, 0, 0, 0, 0,
         ex(2'b01, 2'b01, 2'b00, 8'h00, 8'h0F, 2'b00, 2'b00, 0), "R2 open");
    do_reset();
    send(2'b00, 2'b00, 2'b00, 2'b01, 5, 0, 0, 0, ERR, "R11 open state cleared by reset");

    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule